// File: doc/BRIEF.md
# Space-Vector Modulator for a Two-Level Three-Leg Inverter

This block drives the six gates of a two-level, three-leg voltage-source inverter. A reference angle and a modulation index are sampled once per switching period. From the angle the block finds one of six 60° sectors and the angle inside that sector. It reads two sine values from a quarter-wave table that is computed when the design is elaborated, and from them it derives the dwell times of the two active vectors that bound the sector and of the zero vectors. Over the next period it plays those dwell times out against a period counter as a pattern that is symmetric about the centre of the period.

Zero vectors always occupy both ends of every period. An upstream rectifier can therefore commutate at period boundaries while the inverter applies a zero vector, and no separate synchronising logic is needed. The block is meant to sit behind a power-flow controller that supplies the angle and the index. It sits in front of a dead-time stage that is not part of this block.

With default parameters a period lasts 128 clocks (64 per half), a turn is divided into 96 angle steps (16 per sector), and the index is a 10-bit fraction of 1024.

Top module: `svm_modulator`

## Requirements
- R1: `ang_i` counts in steps of 60°/16 (3.75°), so a full turn is 96 steps. An input of 96 to 127 behaves exactly as that value minus 96.
- R2: The sector is k = floor(angle/16). Its first active vector is taken from the list 100, 110, 010, 011, 001, 101 at position k, and its second active vector is the next entry in that list, wrapping from 101 back to 100. Vector bits are ordered leg a, leg b, leg c (MSB first), and a 1 means the upper gate of that leg is on. No other non-zero vector ever appears in a period.
- R3: Let M = min(mod_i, 886)/1024 and θs = (angle mod 16)·3.75°. In each half period the first active vector lasts floor(M·sin(60°−θs)·64) cycles and the second lasts floor(M·sin(θs)·64) cycles, each within ±1 cycle.
- R4: The z cycles of a half period that are left after the active vectors are split as follows: floor(z/2) cycles go to 000 at the outer end, and the rest go to 111 at the centre.
- R5: The order within a period is 000, first active, second active, 111, second active, first active, 000. Cycle j of a period shows the same vector as cycle 127−j.
- R6: Cycle 0 and cycle 127 of every period show vector 000.
- R7: Any `mod_i` above 886 (0.866 of full scale) produces the same pattern as 886.
- R8: `ang_i` and `mod_i` are sampled only at the clock edge that starts a period. A change during a period has no effect on that period.
- R9: After reset the counter is at cycle 0, and the first period is all zero vectors: 000 on cycles 0–31 and 96–127, and 111 on cycles 32–95. Inputs are first sampled at the edge that ends this period.
- R10: `gate_lo_o` is the bitwise complement of `gate_hi_o` in every cycle, so the two gates of a leg are never on together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ang_i | input | 7 | Reference angle in 3.75° steps |
| mod_i | input | 10 | Modulation index, fraction of 1024 |
| gate_hi_o | output | 3 | Upper gates, bit 2 = leg a |
| gate_lo_o | output | 3 | Lower gates, bit 2 = leg a |

## Verification
The bench sweeps every angle step at zero, half and maximum index. This catches three kinds of error. A sector or vector table that is off by one shows up as a foreign vector. A sine index that is mirrored the wrong way swaps the two active dwell times. At θs = 0 the second vector must be missing, and a sector wrap that is wrong shows a stale vector at angle 95. Clamping is checked by comparing the patterns for indices 887 and 1023 with the pattern for 886. A missing clamp would eat the zero time and let an active vector reach the period edge. Input folding, and changes to the inputs in the middle of a period, are checked the same way against reference patterns. A design that latches early would break the mirror symmetry of the period.

// File: rtl/svm_pkg.sv
package svm_pkg;

  typedef logic [2:0] vec_t;

  typedef enum logic [1:0] {
    PH_Z0 = 2'd0,
    PH_A  = 2'd1,
    PH_B  = 2'd2,
    PH_Z7 = 2'd3
  } phase_t;

  // Vector at the start edge of sector k, counter-clockwise rotation.
  function automatic vec_t sector_vec(input logic [2:0] k);
    case (k)
      3'd0:    return 3'b100;
      3'd1:    return 3'b110;
      3'd2:    return 3'b010;
      3'd3:    return 3'b011;
      3'd4:    return 3'b001;
      default: return 3'b101;
    endcase
  endfunction

  function automatic logic [2:0] next_sector(input logic [2:0] k);
    return (k == 3'd5) ? 3'd0 : k + 3'd1;
  endfunction

  // sin(idx * 60deg / steps) in Q30, odd Taylor series to the 13th power.
  function automatic longint sine_q30(input int idx, input int steps);
    longint x;
    longint term;
    longint acc;
    x    = (longint'(idx) * 64'sd1124419809) / longint'(steps);
    term = x;
    acc  = x;
    for (int k = 1; k <= 6; k++) begin
      term = (term * x) >>> 30;
      term = (term * x) >>> 30;
      term = -(term / longint'((2 * k) * (2 * k + 1)));
      acc  = acc + term;
    end
    return (acc < 0) ? 64'sd0 : acc;
  endfunction

endpackage

// File: rtl/svm_sine_rom.sv
module svm_sine_rom #(
  parameter int SEC_STEPS = 16,
  parameter int SIN_FRAC  = 14,
  localparam int ENTRIES  = SEC_STEPS * 3 / 2 + 1,
  localparam int IDX_W    = $clog2(ENTRIES),
  localparam int SIN_W    = SIN_FRAC + 1
) (
  input  logic [IDX_W-1:0] idx_a,
  input  logic [IDX_W-1:0] idx_b,
  output logic [SIN_W-1:0] val_a,
  output logic [SIN_W-1:0] val_b
);

  logic [SIN_W-1:0] qwave [ENTRIES];

  // Quarter-wave table, 0 to 90 degrees, built at elaboration.
  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    localparam longint RAW = svm_pkg::sine_q30(i, SEC_STEPS);
    assign qwave[i] = SIN_W'(RAW >>> (30 - SIN_FRAC));
  end

  assign val_a = qwave[idx_a];
  assign val_b = qwave[idx_b];

endmodule

// File: rtl/svm_dwell.sv
module svm_dwell #(
  parameter int HALF      = 64,
  parameter int SEC_STEPS = 16,
  parameter int M_W       = 10,
  parameter int SIN_FRAC  = 14,
  localparam int FULL     = 6 * SEC_STEPS,
  localparam int ANG_W    = $clog2(FULL),
  localparam int TW       = $clog2(HALF + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [ANG_W-1:0] ang_i,
  input  logic [M_W-1:0]   mod_i,
  output logic [2:0]       sec_o,
  output logic [TW-1:0]    t1_o,
  output logic [TW-1:0]    t2_o,
  output logic [TW-1:0]    t3_o
);

  localparam int ENTRIES   = SEC_STEPS * 3 / 2 + 1;
  localparam int IDX_W     = $clog2(ENTRIES);
  localparam int SIN_W     = SIN_FRAC + 1;
  localparam int M_MAX     = (866 * (1 << M_W)) / 1000;
  localparam int CLAMP_LIM = (M_MAX * HALF) >> M_W;
  localparam int PROD_W    = M_W + SIN_W + $clog2(HALF) + 1;

  function automatic logic [TW-1:0] scale_dwell(input logic [M_W-1:0] m,
                                                input logic [SIN_W-1:0] s);
    logic [PROD_W-1:0] p;
    p = PROD_W'(m) * PROD_W'(s) * PROD_W'(HALF);
    return TW'(p >> (M_W + SIN_FRAC));
  endfunction

  logic [ANG_W-1:0] ang_f;
  logic [ANG_W-1:0] sec_w;
  logic [ANG_W-1:0] theta;
  logic [M_W-1:0]   m_c;
  logic [IDX_W-1:0] idx_a;
  logic [IDX_W-1:0] idx_b;
  logic [SIN_W-1:0] sin_a;
  logic [SIN_W-1:0] sin_b;
  logic [TW-1:0]    ha;
  logic [TW-1:0]    hb;
  logic [TW-1:0]    hz;
  logic [TW-1:0]    q0;

  always_comb begin
    ang_f = (ang_i >= ANG_W'(FULL)) ? ang_i - ANG_W'(FULL) : ang_i;
    sec_w = ang_f / ANG_W'(SEC_STEPS);
    theta = ang_f - sec_w * ANG_W'(SEC_STEPS);
    m_c   = (mod_i > M_W'(M_MAX)) ? M_W'(M_MAX) : mod_i;
    idx_a = IDX_W'(SEC_STEPS) - IDX_W'(theta);
    idx_b = IDX_W'(theta);
  end

  svm_sine_rom #(
    .SEC_STEPS(SEC_STEPS),
    .SIN_FRAC (SIN_FRAC)
  ) u_rom (
    .idx_a(idx_a),
    .idx_b(idx_b),
    .val_a(sin_a),
    .val_b(sin_b)
  );

  always_comb begin
    ha = scale_dwell(m_c, sin_a);
    hb = scale_dwell(m_c, sin_b);
    hz = TW'(HALF) - ha - hb;
    q0 = hz >> 1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_o <= 3'd0;
      t1_o  <= TW'(HALF / 2);
      t2_o  <= TW'(HALF / 2);
      t3_o  <= TW'(HALF / 2);
    end else if (load) begin
      sec_o <= 3'(sec_w);
      t1_o  <= q0;
      t2_o  <= q0 + ha;
      t3_o  <= q0 + ha + hb;
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (t3_o <= TW'(HALF)) && (t1_o <= t2_o) && (t2_o <= t3_o));

  // R7
  clamp_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (t3_o - t1_o) <= TW'(CLAMP_LIM));

endmodule

// File: rtl/svm_sequencer.sv
module svm_sequencer #(
  parameter int HALF   = 64,
  localparam int PER   = 2 * HALF,
  localparam int CW    = $clog2(PER),
  localparam int TW    = $clog2(HALF + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    sec_i,
  input  logic [TW-1:0] t1_i,
  input  logic [TW-1:0] t2_i,
  input  logic [TW-1:0] t3_i,
  output logic          load_o,
  output svm_pkg::vec_t vec_o
);

  import svm_pkg::*;

  logic [CW-1:0] cnt_q;
  logic [TW-1:0] h;
  phase_t        phase;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (load_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end

  assign load_o = (cnt_q == CW'(PER - 1));

  // Position inside the half period, mirrored in the second half.
  always_comb begin
    if (cnt_q < CW'(HALF)) h = TW'(cnt_q);
    else                   h = TW'(CW'(PER - 1) - cnt_q);
  end

  always_comb begin
    if (h < t1_i)      phase = PH_Z0;
    else if (h < t2_i) phase = PH_A;
    else if (h < t3_i) phase = PH_B;
    else               phase = PH_Z7;
  end

  always_comb begin
    case (phase)
      PH_Z0:   vec_o = 3'b000;
      PH_A:    vec_o = sector_vec(sec_i);
      PH_B:    vec_o = sector_vec(next_sector(sec_i));
      default: vec_o = 3'b111;
    endcase
  end

  // R6
  edge_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 || cnt_q == CW'(PER - 1)) |-> (vec_o == 3'b000));

  // R5
  phase_order_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0 && cnt_q < CW'(HALF)) |-> (phase >= $past(phase)));

  // R5
  centre_mirror_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CW'(HALF)) |-> (vec_o == $past(vec_o)));

endmodule

// File: rtl/svm_modulator.sv
module svm_modulator #(
  parameter int HALF      = 64,
  parameter int SEC_STEPS = 16,
  parameter int M_W       = 10,
  parameter int SIN_FRAC  = 14,
  localparam int ANG_W    = $clog2(6 * SEC_STEPS),
  localparam int TW       = $clog2(HALF + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ANG_W-1:0] ang_i,
  input  logic [M_W-1:0]   mod_i,
  output logic [2:0]       gate_hi_o,
  output logic [2:0]       gate_lo_o
);

  logic          load;
  logic [2:0]    sec;
  logic [TW-1:0] t1;
  logic [TW-1:0] t2;
  logic [TW-1:0] t3;
  svm_pkg::vec_t vec;

  svm_dwell #(
    .HALF     (HALF),
    .SEC_STEPS(SEC_STEPS),
    .M_W      (M_W),
    .SIN_FRAC (SIN_FRAC)
  ) u_dwell (
    .clk  (clk),
    .rst  (rst),
    .load (load),
    .ang_i(ang_i),
    .mod_i(mod_i),
    .sec_o(sec),
    .t1_o (t1),
    .t2_o (t2),
    .t3_o (t3)
  );

  svm_sequencer #(
    .HALF(HALF)
  ) u_seq (
    .clk   (clk),
    .rst   (rst),
    .sec_i (sec),
    .t1_i  (t1),
    .t2_i  (t2),
    .t3_i  (t3),
    .load_o(load),
    .vec_o (vec)
  );

  assign gate_hi_o = vec;
  assign gate_lo_o = ~vec;

endmodule

// File: tb/svm_modulator_test.sv
module svm_modulator_test;

  localparam int P    = 128;
  localparam int H    = 64;
  localparam real PI  = 3.14159265358979;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] ang_i = '0;
  logic [9:0] mod_i = '0;
  logic [2:0] gate_hi_o;
  logic [2:0] gate_lo_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [2:0] cap [P];
  logic [2:0] ref_cap [P];

  always #2.5 clk = ~clk;

  svm_modulator uut (
    .clk      (clk),
    .rst      (rst),
    .ang_i    (ang_i),
    .mod_i    (mod_i),
    .gate_hi_o(gate_hi_o),
    .gate_lo_o(gate_lo_o)
  );

  function automatic logic [2:0] bvec(input int k);
    logic [2:0] t [6] = '{3'b100, 3'b110, 3'b010, 3'b011, 3'b001, 3'b101};
    return t[k % 6];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One period with inputs presented before its starting edge.
  task automatic run_period(input int ang, input int m, input bit garble);
    bit comp_ok;
    int bad;
    comp_ok = 1'b1;
    bad = 0;
    ang_i = 7'(ang);
    mod_i = 10'(m);
    for (int j = 0; j < P; j++) begin
      @(negedge clk);
      cap[j] = gate_hi_o;
      if (gate_lo_o !== ~gate_hi_o) begin
        comp_ok = 1'b0;
        bad = int'(gate_lo_o);
      end
      if (garble && j == H - 1) begin
        ang_i = ang_i ^ 7'h2b;
        mod_i = ~mod_i;
      end
    end
    check(comp_ok, "R10", "complementary gates", bad, 0);
  endtask

  task automatic save_ref();
    for (int j = 0; j < P; j++) ref_cap[j] = cap[j];
  endtask

  task automatic compare_ref(input string req, input int tag);
    int diff;
    diff = -1;
    for (int j = P - 1; j >= 0; j--) if (cap[j] !== ref_cap[j]) diff = j;
    check(diff < 0, req, "pattern equal to reference, first differing cycle",
          diff, -1);
    if (diff >= 0) $display("  (tag %0d)", tag);
  endtask

  task automatic analyze(input int ang, input int m);
    int af, k, th, mc, ea, eb, na, nb, n0, n7, rank, last, mis;
    logic [2:0] va, vb;
    real da, db;
    bit order_ok;
    af = (ang >= 96) ? ang - 96 : ang;
    k  = af / 16;
    th = af % 16;
    mc = (m > 886) ? 886 : m;
    va = bvec(k);
    vb = bvec(k + 1);
    da = (mc / 1024.0) * $sin((16 - th) * PI / 48.0) * H;
    db = (mc / 1024.0) * $sin(th * PI / 48.0) * H;
    ea = $rtoi(da);
    eb = $rtoi(db);
    na = 0; nb = 0; n0 = 0; n7 = 0; last = 0; order_ok = 1'b1;
    for (int j = 0; j < H; j++) begin
      if (cap[j] == 3'b000)      begin rank = 0; n0++; end
      else if (cap[j] == va)     begin rank = 1; na++; end
      else if (cap[j] == vb)     begin rank = 2; nb++; end
      else if (cap[j] == 3'b111) begin rank = 3; n7++; end
      else rank = 9;
      if (rank < last || rank == 9) order_ok = 1'b0;
      last = rank;
    end
    // R2 only sector vectors, in the order of R5
    check(order_ok, "R2", "vector set and order, angle", ang, k);
    mis = 0;
    for (int j = 0; j < H; j++) if (cap[j] !== cap[P - 1 - j]) mis++;
    // R5 mirror symmetry
    check(mis == 0, "R5", "mirror mismatches", mis, 0);
    // R6 zero at both period edges
    check(cap[0] == 3'b000 && cap[P - 1] == 3'b000, "R6", "edge vectors",
          int'({cap[0], cap[P - 1]}), 0);
    // R3 dwell of both active vectors
    check(na - ea <= 1 && ea - na <= 1, "R3", "first active dwell", na, ea);
    check(nb - eb <= 1 && eb - nb <= 1, "R3", "second active dwell", nb, eb);
    // R4 zero split
    check(n0 == (H - na - nb) / 2, "R4", "outer 000 cycles", n0, (H - na - nb) / 2);
    check(n7 == (H - na - nb) - (H - na - nb) / 2, "R4", "centre 111 cycles",
          n7, (H - na - nb) - (H - na - nb) / 2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all requirements actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int mis;
    bit comp_ok;
    int mlist [3] = '{0, 512, 886};
    int clist [6] = '{0, 7, 15, 40, 77, 95};
    int glist [3] = '{5, 50, 90};
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9 inputs applied during the first period must not act yet
    ang_i = 7'd20;
    mod_i = 10'd800;
    comp_ok = 1'b1;
    cap[0] = gate_hi_o;
    if (gate_lo_o !== ~gate_hi_o) comp_ok = 1'b0;
    for (int j = 1; j < P; j++) begin
      @(negedge clk);
      cap[j] = gate_hi_o;
      if (gate_lo_o !== ~gate_hi_o) comp_ok = 1'b0;
    end
    check(cap[0] == 3'b000, "R9", "vector at cycle 0 after reset", int'(cap[0]), 0);
    mis = 0;
    for (int j = 0; j < P; j++) begin
      if (cap[j] !== ((j >= 32 && j < 96) ? 3'b111 : 3'b000)) mis++;
    end
    check(mis == 0, "R9", "first period zero-only mismatches", mis, 0);
    check(comp_ok, "R10", "complementary gates after reset", 0, 0);

    // R3 R4 R5 R6: exhaustive angle sweep at three indices
    foreach (mlist[i]) begin
      for (int a = 0; a < 96; a++) begin
        run_period(a, mlist[i], 1'b0);
        analyze(a, mlist[i]);
      end
    end

    // R1 folded angles
    for (int a = 96; a < 128; a++) begin
      run_period(a - 96, 700, 1'b0);
      save_ref();
      run_period(a, 700, 1'b0);
      compare_ref("R1", a);
      analyze(a, 700);
    end

    // R7 clamp of large indices
    foreach (clist[i]) begin
      run_period(clist[i], 886, 1'b0);
      save_ref();
      run_period(clist[i], 1023, 1'b0);
      compare_ref("R7", clist[i]);
      analyze(clist[i], 1023);
      run_period(clist[i], 887, 1'b0);
      compare_ref("R7", clist[i]);
    end

    // R8 mid-period input changes ignored
    foreach (glist[i]) begin
      run_period(glist[i], 600, 1'b0);
      save_ref();
      run_period(glist[i], 600, 1'b1);
      compare_ref("R8", glist[i]);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule